// File: doc/BRIEF.md
# SPI ADC Conversion Sequencer

This block runs one conversion on an external 8-channel, 12-bit analog-to-digital converter that sits on an SPI link. A one-cycle start request, together with a 3-bit channel number and a single-ended/differential select, launches a complete transaction. The block drives chip select low and waits a fixed guard interval. It then clocks a 24-bit frame in SPI mode 3 while it collects the converter's reply. A second guard interval follows before chip select goes high again and the 12-bit sample is presented with a one-cycle done strobe.

The serial clock is made inside the block by dividing the system clock (by 64 by default). The command frame is packed across byte boundaries. The start marker, mode bit and channel MSB sit in the first byte, and the two low channel bits sit at the top of the second byte. The result is rebuilt from the low nibble of the second received byte and the whole third byte. A host that wants averaging or channel scanning issues further start requests after each done.

Top module: `adc_seq_top`

## Requirements
- R1: While reset (`rst_n` low, sampled synchronously) is applied and whenever no transaction is running, `cs_n_o`, `sck_o` and `mosi_o` are high, `busy_o` and `done_o` are low; reset also clears `result_o` to zero and abandons any transaction in progress.
- R2: A `start_i` pulse seen while idle makes `cs_n_o` go low and `busy_o` go high at the next clock edge; `busy_o` stays high exactly as long as `cs_n_o` is low.
- R3: Each transaction has 24 SCK periods of `SCK_DIV` system clocks, each low for `SCK_DIV/2` clocks then high for `SCK_DIV/2` clocks (SCK idles high, SPI mode 3); SCK is low only while `cs_n_o` is low; with defaults `cs_n_o` is low for 1540 clocks.
- R4: MOSI carries 24 bits MSB first, as seen on SCK rising edges: byte 0 is `0x04 | (single_i<<1) | chan_i[2]`, byte 1 is `chan_i[1:0]` in bits 7:6 with the rest zero, byte 2 is zero; channel and mode are latched with the start pulse.
- R5: While `cs_n_o` stays low, `mosi_o` changes only on the clock edge at which `sck_o` falls.
- R6: `miso_i` is sampled on SCK rising edges; `result_o` = {received byte 1 bits 3:0, received byte 2}; received byte 0 and the upper nibble of byte 1 have no effect on the result.
- R7: The first SCK falling edge comes exactly `GUARD_CLKS`+1 system clocks after `cs_n_o` falls (18 with defaults).
- R8: `cs_n_o` rises exactly `GUARD_CLKS`+1 system clocks after the last SCK rising edge (18 with defaults).
- R9: `done_o` is high for exactly one clock, on the same edge at which `cs_n_o` rises and `busy_o` falls; `result_o` changes only together with `done_o` and holds its value until the next done.
- R10: A `start_i` pulse while `busy_o` is high is ignored: the running frame, its result and its single done are unchanged and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to run a conversion |
| chan_i | input | 3 | Channel number to convert |
| single_i | input | 1 | 1 = single-ended input, 0 = differential pair |
| busy_o | output | 1 | High while a transaction is running |
| done_o | output | 1 | One-cycle strobe when `result_o` is updated |
| result_o | output | 12 | Latest 12-bit conversion result |
| sck_o | output | 1 | Serial clock to the converter, idles high |
| mosi_o | output | 1 | Serial command data to the converter |
| miso_i | input | 1 | Serial reply data from the converter |
| cs_n_o | output | 1 | Converter chip select, active low |

## Verification
The hardest situations to reach are the ones where the host acts while a frame is in flight: a second start request in the middle of the shifting phase, and a reset that arrives hundreds of cycles into a transaction. The bench runs its own converter model. It answers each falling SCK edge with the next bit of a chosen 24-bit reply and records MOSI on each rising edge. Replies are filled with ones in the discarded bit positions, so a wrong field boundary shows in the result. The mid-frame start and mid-frame reset are driven at fixed cycle offsets into the frame. The frame, the timing and the done count are then compared against the undisturbed case.

// File: rtl/adc_seq_pkg.sv
// Shared definitions for the SPI ADC conversion sequencer.
// Assumes a 24-bit frame carrying a 12-bit sample and a 3-bit channel field.
package adc_seq_pkg;

    localparam int FRAME_BITS = 24;
    localparam int RES_BITS   = 12;
    localparam int CHAN_BITS  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

    // Packs the command: marker, mode and channel MSB in byte 0, channel LSBs atop byte 1.
    function automatic logic [FRAME_BITS-1:0] make_cmd(input logic single,
                                                       input logic [CHAN_BITS-1:0] ch);
        logic [7:0] b0;
        logic [7:0] b1;
        b0 = {5'b00001, single, ch[2]};
        b1 = {ch[1:0], 6'b000000};
        return {b0, b1, 8'h00};
    endfunction

endpackage

// File: rtl/adc_seq_sckgen.sv
// Phase counter for the serial clock.
// While run is high it walks 0..SCK_DIV-1; phase 0 marks a falling edge,
// phase SCK_DIV/2 a rising edge. Assumes SCK_DIV is even and at least 2.
module adc_seq_sckgen #(
    parameter int SCK_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic fall_o,
    output logic rise_o
);
    localparam int PW = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(SCK_DIV - 1);
    localparam logic [PW-1:0] PH_HALF = PW'(SCK_DIV / 2);

    logic [PW-1:0] ph;

    // Advance the phase while shifting, park it at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph <= '0;
        end else if (ph == PH_LAST) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    // Decode the two edge strobes from the phase.
    always_comb begin
        fall_o = run && (ph == '0);
        rise_o = run && (ph == PH_HALF);
    end

endmodule

// File: rtl/adc_seq_shreg.sv
// Transmit and receive shift registers.
// Transmit: loaded with the command, moves one bit to mosi_o per shift strobe,
// MSB first; park forces mosi_o back to its idle-high level.
// Receive: keeps only the last KEEP_W bits sampled, so older bits fall off the top.
module adc_seq_shreg #(
    parameter int TX_W   = 24,
    parameter int KEEP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TX_W-1:0]   load_val,
    input  logic              shift,
    input  logic              sample,
    input  logic              park,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic [KEEP_W-1:0] rx_o
);
    logic [TX_W-1:0]   tx;
    logic [KEEP_W-1:0] rx;

    // Command register and MOSI driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx     <= '0;
            mosi_o <= 1'b1;
        end else if (load) begin
            tx <= load_val;
        end else if (shift) begin
            tx     <= {tx[TX_W-2:0], 1'b0};
            mosi_o <= tx[TX_W-1];
        end else if (park) begin
            mosi_o <= 1'b1;
        end
    end

    // Reply capture on sample strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rx <= '0;
        end else if (sample) begin
            rx <= {rx[KEEP_W-2:0], miso_i};
        end
    end

    assign rx_o = rx;

endmodule

// File: rtl/adc_seq_top.sv
// SPI ADC conversion sequencer, top level.
// Runs one select / guard / 24-bit shift / guard / release sequence per start
// request in SPI mode 3. Assumes GUARD_CLKS >= 1 and an even SCK_DIV >= 2.
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int SCK_DIV    = 64,
    parameter int GUARD_CLKS = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CHAN_BITS-1:0] chan_i,
    input  logic                 single_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [RES_BITS-1:0]  result_o,
    output logic                 sck_o,
    output logic                 mosi_o,
    input  logic                 miso_i,
    output logic                 cs_n_o
);
    localparam int GW = $clog2(GUARD_CLKS + 1);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [GW-1:0] G_SETUP_END = GW'(GUARD_CLKS - 1);
    localparam logic [GW-1:0] G_HOLD_END  = GW'(GUARD_CLKS);
    localparam logic [BW-1:0] LAST_BIT    = BW'(FRAME_BITS - 1);

    seq_state_e          state;
    logic [GW-1:0]       gcnt;
    logic [BW-1:0]       bitcnt;
    logic                fall_stb;
    logic                rise_stb;
    logic                accept;
    logic                release_now;
    logic [RES_BITS-1:0] rx_keep;

    // Decode the start acceptance and the release point.
    always_comb begin
        accept      = (state == ST_IDLE) && start_i;
        release_now = (state == ST_HOLD) && (gcnt == G_HOLD_END);
    end

    adc_seq_sckgen #(
        .SCK_DIV (SCK_DIV)
    ) u_sckgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_SHIFT),
        .fall_o (fall_stb),
        .rise_o (rise_stb)
    );

    adc_seq_shreg #(
        .TX_W   (FRAME_BITS),
        .KEEP_W (RES_BITS)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (make_cmd(single_i, chan_i)),
        .shift    (fall_stb),
        .sample   (rise_stb),
        .park     (release_now),
        .miso_i   (miso_i),
        .mosi_o   (mosi_o),
        .rx_o     (rx_keep)
    );

    // Sequencer: select, guard, shift, guard, release with result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            gcnt     <= '0;
            bitcnt   <= '0;
            sck_o    <= 1'b1;
            cs_n_o   <= 1'b1;
            done_o   <= 1'b0;
            result_o <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state  <= ST_SETUP;
                        cs_n_o <= 1'b0;
                        gcnt   <= '0;
                        bitcnt <= '0;
                    end
                end
                ST_SETUP: begin
                    if (gcnt == G_SETUP_END) begin
                        state <= ST_SHIFT;
                        gcnt  <= '0;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (fall_stb) begin
                        sck_o <= 1'b0;
                    end
                    if (rise_stb) begin
                        sck_o <= 1'b1;
                        if (bitcnt == LAST_BIT) begin
                            state <= ST_HOLD;
                            gcnt  <= '0;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (release_now) begin
                        state    <= ST_IDLE;
                        cs_n_o   <= 1'b1;
                        done_o   <= 1'b1;
                        result_o <= rx_keep;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/adc_seq_checker.sv
// Protocol checker for adc_seq_top, attached with bind.
// Watches only the top-level ports.
module adc_seq_checker #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic [RES_W-1:0] result_o,
    input logic             sck_o,
    input logic             mosi_o,
    input logic             cs_n_o
);

    AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && sck_o && mosi_o)); // R1

    AST_BUSY_TRACKS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == !cs_n_o); // R2

    AST_SCK_LOW_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_o |-> !cs_n_o); // R3

    AST_MOSI_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && $past(!cs_n_o) && !$fell(sck_o)) |-> $stable(mosi_o)); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($rose(cs_n_o) && !busy_o)); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o)); // R9

endmodule

bind adc_seq_top adc_seq_checker #(
    .RES_W (adc_seq_pkg::RES_BITS)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .sck_o    (sck_o),
    .mosi_o   (mosi_o),
    .cs_n_o   (cs_n_o)
);

// File: tb/adc_seq_top_tb.sv
`timescale 1ns/100ps
// Bench for adc_seq_top: vector table pass, then directed corner cases.
module adc_seq_top_tb;

    localparam int DIV   = 64;
    localparam int GUARD = 17;
    localparam int NBIT  = 24;
    localparam int GAP   = GUARD + 1;
    localparam int CS_LOW_LEN = 2 * GAP + (NBIT - 1) * DIV + DIV / 2;
    localparam int NVEC  = 6;
    // Fields: [39:37] channel, [36] single, [35:12] converter reply, [11:0] expected result
    localparam logic [39:0] VEC [NVEC] = '{
        {3'd0, 1'b1, 24'h000000, 12'h000},
        {3'd7, 1'b0, 24'hFFFFFF, 12'hFFF},
        {3'd5, 1'b1, 24'h123456, 12'h456},
        {3'd2, 1'b0, 24'hABCDEF, 12'hDEF},
        {3'd3, 1'b1, 24'hFFFA5C, 12'hA5C},
        {3'd4, 1'b0, 24'hF0F00F, 12'h00F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  chan_i = '0;
    logic        single_i = 1'b0;
    logic        busy_o, done_o, sck_o, mosi_o, cs_n_o;
    logic        miso_i = 1'b0;
    logic [11:0] result_o;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    adc_seq_top #(.SCK_DIV(DIV), .GUARD_CLKS(GUARD)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .single_i(single_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .sck_o(sck_o), .mosi_o(mosi_o),
        .miso_i(miso_i), .cs_n_o(cs_n_o)
    );

    always #2.5 clk = ~clk;

    // Converter model and line monitor, evaluated at the falling clock edge.
    logic [23:0] reply = '0;
    logic [23:0] cap = '0;
    int cyc = 0, t_cs = 0, t_first = 0, t_last_rise = 0, t_csr = 0;
    int nfall = 0, lowcnt = 0, ndone = 0;
    logic prev_cs = 1'b1, prev_sck = 1'b1;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_cs && !cs_n_o) begin
            t_cs = cyc; nfall = 0; lowcnt = 0; cap = '0;
        end
        if (prev_sck && !sck_o) begin
            if (nfall == 0) t_first = cyc;
            if (nfall < NBIT) miso_i = reply[NBIT-1-nfall];
            nfall = nfall + 1;
        end
        if (!prev_sck && sck_o) begin
            cap = {cap[22:0], mosi_o};
            t_last_rise = cyc;
        end
        if (!sck_o) lowcnt = lowcnt + 1;
        if (!prev_cs && cs_n_o) t_csr = cyc;
        if (done_o) ndone = ndone + 1;
        prev_cs = cs_n_o;
        prev_sck = sck_o;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [23:0] frame_of(input logic [2:0] ch, input logic sg);
        return {5'b00001, sg, ch[2], ch[1:0], 6'b0, 8'h00};
    endfunction

    // One full conversion; a non-zero intrude_at pulses a second start mid-frame.
    task automatic run_txn(input logic [2:0] ch, input logic sg, input logic [23:0] rep,
                           input logic [11:0] exp, input int intrude_at);
        int n;
        int done_base;
        logic [11:0] prev_res;
        reply = rep;
        prev_res = result_o;
        done_base = ndone;
        @(negedge clk);
        start_i = 1'b1; chan_i = ch; single_i = sg;
        @(negedge clk);
        start_i = 1'b0;
        chan_i = ~ch; single_i = ~sg;
        #1;
        chk(!cs_n_o && busy_o, "R2 select after start", {cs_n_o, busy_o}, 2'b01);
        n = 0;
        while (!done_o && n < 4000) begin
            if (n == 200) chk(result_o == prev_res, "R9 result held during frame", result_o, prev_res);
            if (intrude_at != 0 && n == intrude_at) begin
                @(negedge clk); start_i = 1'b1; chan_i = ~ch; single_i = ~sg;
                @(negedge clk); start_i = 1'b0; #1;
                n = n + 2;
            end else begin
                tick();
                n++;
            end
        end
        chk(done_o == 1'b1, "R9 done seen", done_o, 1'b1);
        chk(!busy_o && cs_n_o, "R9 release with done", {busy_o, cs_n_o}, 2'b01);
        chk(result_o == exp, "R6 result", result_o, exp);
        chk(cap == frame_of(ch, sg), "R4 command frame", cap, frame_of(ch, sg));
        chk(nfall == NBIT, "R3 falling edges", nfall, NBIT);
        chk(lowcnt == NBIT * DIV / 2, "R3 low time", lowcnt, NBIT * DIV / 2);
        chk(t_csr - t_cs == CS_LOW_LEN, "R3 select length", t_csr - t_cs, CS_LOW_LEN);
        chk(t_first - t_cs == GAP, "R7 setup gap", t_first - t_cs, GAP);
        chk(t_csr - t_last_rise == GAP, "R8 hold gap", t_csr - t_last_rise, GAP);
        tick();
        chk(!done_o, "R9 done one cycle", done_o, 1'b0);
        repeat (20) tick();
        chk(result_o == exp, "R9 result kept", result_o, exp);
        chk(ndone - done_base == 1, "R10 single done", ndone - done_base, 1);
        chk(cs_n_o && sck_o && mosi_o && !busy_o, "R1 idle after frame",
            {cs_n_o, sck_o, mosi_o, busy_o}, 4'b1110);
    endtask

    initial begin
        repeat (4) tick();
        chk(cs_n_o && sck_o && mosi_o && !busy_o && !done_o, "R1 reset levels",
            {cs_n_o, sck_o, mosi_o, busy_o, done_o}, 5'b11100);
        chk(result_o == 12'h000, "R1 reset result", result_o, 12'h000);
        rst_n = 1'b1;
        repeat (3) tick();

        for (int i = 0; i < NVEC; i++) begin
            run_txn(VEC[i][39:37], VEC[i][36], VEC[i][35:12], VEC[i][11:0], 0);
        end

        // R10: a second request in the middle of the shift phase is dropped.
        run_txn(3'd6, 1'b1, 24'h00F3C1, 12'h3C1, 300);
        repeat (200) tick();
        chk(cs_n_o && ndone >= NVEC + 1, "R10 no follow-up frame", cs_n_o, 1'b1);

        // R1: reset in the middle of a frame returns every line to idle.
        reply = 24'hFFFFFF;
        @(negedge clk); start_i = 1'b1; chan_i = 3'd1; single_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (500) tick();
        chk(!cs_n_o, "R2 frame under way", cs_n_o, 1'b0);
        rst_n = 1'b0;
        repeat (3) tick();
        chk(cs_n_o && sck_o && mosi_o && !busy_o && !done_o, "R1 mid-frame reset",
            {cs_n_o, sck_o, mosi_o, busy_o, done_o}, 5'b11100);
        chk(result_o == 12'h000, "R1 result cleared", result_o, 12'h000);
        rst_n = 1'b1;
        repeat (3) tick();
        run_txn(3'd1, 1'b1, 24'h0009A7, 12'h9A7, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule